// File: doc/BRIEF.md
# Shift-Register LIFO Stack

This block is an addressless last-in first-out store. It is built as a chain of word registers in which each cell loads directly from its neighbours. A push writes the input word into the top cell, and every stored word moves one cell deeper in the same cycle. A pop hands the top word to the output, and every word moves one cell toward the top. The bottom cell is refilled with zeros. A peek copies the top word to the output and leaves the cells and the count alone.

An occupancy counter drives the empty and full flags. Full is raised when the count reaches one less than the number of cells, so the deepest cell never holds a live word. Requests that cannot be honoured are dropped and reported with a one-cycle pulse. A push and a pop in the same cycle on a non-empty stack become a swap: the old top word goes out and the new word takes its place.

Top module: `lifo_shift_stack`

## Requirements
- R1: While reset is held and right after it, empty_o is 1, full_o is 0, count_o is 0, and dout_vld_o, ovf_o and unf_o are 0.
- R2: A push alone on a stack that is not full raises count_o by one at the next edge. Words then leave in the reverse of their arrival order.
- R3: A push alone while full_o is 1 leaves the contents and the count unchanged, and ovf_o is 1 for exactly the following cycle.
- R4: A pop alone on a non-empty stack gives dout_vld_o = 1 for one cycle after the edge, with dout_o equal to the most recent word still held, and lowers count_o by one.
- R5: A pop alone while empty_o is 1 leaves the count at 0, keeps dout_vld_o at 0, and gives unf_o = 1 for exactly the following cycle.
- R6: A peek alone on a non-empty stack gives dout_vld_o = 1 with dout_o equal to the top word, leaves count_o unchanged, and a later pop returns the same word. A peek while empty yields no valid output and no pulse.
- R7: empty_o is 1 exactly when count_o is 0, and full_o is 1 exactly when count_o equals DEPTH-1. The two flags are never 1 together.
- R8: A push and a pop together on a non-empty stack output the old top word with dout_vld_o = 1, put din_i in its place, and leave count_o unchanged. This holds even when full.
- R9: A push and a pop together on an empty stack act as a plain push: count_o becomes 1, dout_vld_o stays 0, and unf_o pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Destructive read strobe |
| peek_i | input | 1 | Non-destructive read strobe |
| din_i | input | WIDTH | Word to push |
| dout_o | output | WIDTH | Word read from the top, registered |
| dout_vld_o | output | 1 | dout_o carries a fresh read this cycle |
| empty_o | output | 1 | No words held |
| full_o | output | 1 | Count equals DEPTH-1 |
| ovf_o | output | 1 | One-cycle pulse: a push was dropped |
| unf_o | output | 1 | One-cycle pulse: a pop found nothing |
| count_o | output | $clog2(DEPTH) | Number of words held |

## Verification
Push and pop can land in the same cycle. A peek can also coincide with either of them. The bench forces every combination of the three strobes at every fill level of a four-cell stack: empty, partly filled and full. This covers the swap, the empty-stack push-with-pop and the full-stack swap. A reference model in the bench predicts the output word, the valid flag, the pulses and the count for each step, and drains the stack afterwards to confirm that the swapped word sits on top and the older words keep their order.

// File: rtl/lifo_pkg.sv
// Shared types for the shift-register stack.
// Assumes: one shift action per cycle, chosen by the controller.
package lifo_pkg;
    typedef enum logic [1:0] {
        SH_HOLD = 2'd0,   // cells keep their words
        SH_DOWN = 2'd1,   // push: new word on top, rest one deeper
        SH_UP   = 2'd2,   // pop: every word one toward the top
        SH_SWAP = 2'd3    // top cell replaced, rest hold
    } shift_op_e;
endpackage

// File: rtl/lifo_ctrl.sv
// Decodes the strobes into one shift action, keeps the word count,
// and produces the flag and pulse outputs.
// Assumes: DEPTH >= 2; the count never exceeds DEPTH-1.
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          peek_i,
    output shift_op_e     op_o,
    output logic          rd_fire_o,
    output logic [CW-1:0] count_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          unf_q;

    // flags derived from the stored count
    always_comb begin
        empty_o = (cnt_q == '0);
        full_o  = (cnt_q == LAST);
    end

    // choose the single shift action for this cycle
    always_comb begin
        op_o = SH_HOLD;
        if (push_i && pop_i && !empty_o)
            op_o = SH_SWAP;
        else if (push_i && !full_o)
            op_o = SH_DOWN;
        else if (pop_i && !empty_o)
            op_o = SH_UP;
    end

    // a read of the top word happens on pop or peek with data present
    always_comb rd_fire_o = (pop_i || peek_i) && !empty_o;

    // count update and one-cycle error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            case (op_o)
                SH_DOWN: cnt_q <= cnt_q + CW'(1);
                SH_UP:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
            ovf_q <= push_i && !pop_i && full_o;
            unf_q <= pop_i && empty_o;
        end
    end

    assign count_o = cnt_q;
    assign ovf_o   = ovf_q;
    assign unf_o   = unf_q;
endmodule

// File: rtl/lifo_cell.sv
// One word register of the chain. It loads from the cell above on a
// push, from the cell below on a pop, and from the input word on a
// swap when it is the top cell.
// Assumes: src_dn of the top cell is the pushed word, src_up of the
// bottom cell is zero.
module lifo_cell
    import lifo_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter bit IS_TOP = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  shift_op_e        op_i,
    input  logic [WIDTH-1:0] src_dn_i,
    input  logic [WIDTH-1:0] src_up_i,
    output logic [WIDTH-1:0] q_o
);
    // select the next word for this cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            case (op_i)
                SH_DOWN: q_o <= src_dn_i;
                SH_UP:   q_o <= src_up_i;
                SH_SWAP: if (IS_TOP) q_o <= src_dn_i;
                default: q_o <= q_o;
            endcase
        end
    end
endmodule

// File: rtl/lifo_shift_stack.sv
// Shift-register LIFO: DEPTH word cells chained neighbour to neighbour,
// with a registered read port on the top cell.
// Assumes: DEPTH >= 2; full is declared at DEPTH-1 words, so the deepest
// cell only ever holds zero.
module lifo_shift_stack
    import lifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    localparam int CW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             peek_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             dout_vld_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic [CW-1:0]    count_o
);
    shift_op_e        op;
    logic             rd_fire;
    logic [WIDTH-1:0] cell_q [DEPTH];
    logic [WIDTH-1:0] dout_q;
    logic             vld_q;

    lifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .peek_i    (peek_i),
        .op_o      (op),
        .rd_fire_o (rd_fire),
        .count_o   (count_o),
        .empty_o   (empty_o),
        .full_o    (full_o),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    // the chain of cells: top takes din_i, bottom refills with zero
    for (genvar k = 0; k < DEPTH; k++) begin : g_cell
        logic [WIDTH-1:0] dn_src;
        logic [WIDTH-1:0] up_src;
        if (k == 0) begin : g_top
            assign dn_src = din_i;
        end else begin : g_mid
            assign dn_src = cell_q[k-1];
        end
        if (k == DEPTH - 1) begin : g_bot
            assign up_src = '0;
        end else begin : g_inner
            assign up_src = cell_q[k+1];
        end
        lifo_cell #(.WIDTH(WIDTH), .IS_TOP(k == 0)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .op_i     (op),
            .src_dn_i (dn_src),
            .src_up_i (up_src),
            .q_o      (cell_q[k])
        );
    end

    // registered read port on the top cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= rd_fire;
            if (rd_fire) dout_q <= cell_q[0];
        end
    end

    assign dout_o     = dout_q;
    assign dout_vld_o = vld_q;
endmodule

// File: rtl/lifo_shift_stack_chk.sv
// Port-level properties of the stack, bound into every instance.
// Assumes: sampled on the rising edge, reset synchronous active low.
module lifo_shift_stack_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic          empty_o,
    input logic          full_o,
    input logic          ovf_o,
    input logic          unf_o,
    input logic          dout_vld_o,
    input logic [CW-1:0] count_o
);
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));

    p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (count_o == $past(count_o) + CW'(1)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> (ovf_o && count_o == $past(count_o)));

    p_pop_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=>
            (dout_vld_o && count_o == $past(count_o) - CW'(1)));

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> (unf_o && !dout_vld_o && count_o == '0));

    p_swap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o) |=> (dout_vld_o && count_o == $past(count_o)));

    p_swap_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && empty_o) |=> (unf_o && !dout_vld_o && count_o == CW'(1)));
endmodule

bind lifo_shift_stack lifo_shift_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o),
    .dout_vld_o (dout_vld_o),
    .count_o    (count_o)
);

// File: tb/sim_lifo_shift_stack.sv
`timescale 1ns/1ps
module sim_lifo_shift_stack;
    localparam int DEPTH = 4;
    localparam int WIDTH = 8;
    localparam int CW    = $clog2(DEPTH);
    localparam int CAP   = DEPTH - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_i = 1'b0, pop_i = 1'b0, peek_i = 1'b0;
    logic [WIDTH-1:0] din_i = '0;
    logic [WIDTH-1:0] dout_o;
    logic             dout_vld_o, empty_o, full_o, ovf_o, unf_o;
    logic [CW-1:0]    count_o;

    int total = 0;
    int bad   = 0;
    logic [WIDTH-1:0] mdl [DEPTH];
    int mcnt = 0;
    int seq  = 0;

    always #2.5 clk = ~clk;

    lifo_shift_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .peek_i(peek_i), .din_i(din_i), .dout_o(dout_o),
        .dout_vld_o(dout_vld_o), .empty_o(empty_o), .full_o(full_o),
        .ovf_o(ovf_o), .unf_o(unf_o), .count_o(count_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_i = 0; pop_i = 0; peek_i = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        mcnt = 0;
    endtask

    // apply one strobe combination for one cycle and compare with the model
    task automatic step(input bit pu, input bit po, input bit pk, input bit full_check);
        bit          m_empty, m_full, e_vld, e_ovf, e_unf;
        logic [WIDTH-1:0] e_dout, w;
        string       rd_tag, unf_tag;
        seq++;
        w = WIDTH'(seq * 37 + 11);
        m_empty = (mcnt == 0);
        m_full  = (mcnt == CAP);
        e_vld   = (po || pk) && !m_empty;
        e_dout  = mdl[0];
        e_ovf   = pu && !po && m_full;
        e_unf   = po && m_empty;
        rd_tag  = (pu && po) ? "R8" : (po ? "R4" : "R6");
        unf_tag = pu ? "R9" : "R5";
        push_i = pu; pop_i = po; peek_i = pk; din_i = w;
        if (pu && po && !m_empty) begin
            mdl[0] = w;
        end else if (pu && !m_full) begin
            for (int i = DEPTH - 1; i > 0; i--) mdl[i] = mdl[i-1];
            mdl[0] = w;
            mcnt++;
        end else if (po && !m_empty) begin
            for (int i = 0; i < DEPTH - 1; i++) mdl[i] = mdl[i+1];
            mdl[DEPTH-1] = '0;
            mcnt--;
        end
        @(negedge clk);
        push_i = 0; pop_i = 0; peek_i = 0;
        chk(dout_vld_o == e_vld, rd_tag, int'(dout_vld_o), int'(e_vld));
        if (e_vld) chk(dout_o == e_dout, rd_tag, int'(dout_o), int'(e_dout));
        if (full_check) begin
            chk(ovf_o == e_ovf, "R3", int'(ovf_o), int'(e_ovf));
            chk(unf_o == e_unf, unf_tag, int'(unf_o), int'(e_unf));
            chk(int'(count_o) == mcnt, "R2", int'(count_o), mcnt);
            chk(empty_o == (mcnt == 0), "R7", int'(empty_o), int'(mcnt == 0));
            chk(full_o == (mcnt == CAP), "R7", int'(full_o), int'(mcnt == CAP));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        do_reset();
        // R1: reset state
        rst_n = 1'b0;
        @(negedge clk);
        chk(empty_o == 1'b1, "R1", int'(empty_o), 1);
        chk(full_o == 1'b0, "R1", int'(full_o), 0);
        chk(count_o == '0, "R1", int'(count_o), 0);
        chk(!dout_vld_o && !ovf_o && !unf_o, "R1",
            int'({dout_vld_o, ovf_o, unf_o}), 0);
        rst_n = 1'b1;

        // every strobe combination at every fill level, then a checked drain
        for (int lvl = 0; lvl <= CAP; lvl++) begin
            for (int combo = 0; combo < 8; combo++) begin
                do_reset();
                for (int i = 0; i < lvl; i++) step(1, 0, 0, 1);
                step(combo[2], combo[1], combo[0], 1);
                // a second peek shows R6 leaves the top intact
                step(0, 0, 1, 1);
                // drain: R2 reverse order via model compare
                for (int i = 0; i <= CAP; i++) step(0, 1, 0, 1);
            end
        end

        // repeated overflow attempts at full (R3)
        do_reset();
        for (int i = 0; i < CAP + 3; i++) step(1, 0, 0, 1);
        for (int i = 0; i < CAP; i++) step(0, 1, 0, 1);

        // long mixed sequence driven by a bench-side LFSR
        do_reset();
        lfsr = 16'hACE1;
        for (int n = 0; n < 2000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1] & lfsr[4], lfsr[2] & lfsr[3], 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule